// File: doc/BRIEF.md
# Normalized Min-Sum Check Node Unit

This block performs the check-node half of a layered min-sum decoder iteration for a single parity check of degree up to fifteen. Each input lane carries one signed prior message (variable-to-check) in 8-bit two's complement, read as one sign bit, four integer bits and three fraction bits. A per-lane enable mask says which lanes belong to the current check. Disabled lanes contribute nothing. A node with fewer edges than the lane count is handled by clearing the unused lanes.

One cycle after a valid input, the unit presents a compact 30-bit record that a message store can keep in place of one full message per edge. The record holds the two smallest edge magnitudes after scaling by 0.75, the lane of the smallest, each lane's sign, and the parity of all signs. The same cycle, the unit presents the expanded 6-bit check-to-variable message for every lane, rebuilt from that record. Each lane's message is the scaled minimum magnitude over the other lanes, carrying the sign product of the other lanes. The record and messages stay as they are until the next valid input.

Top module: `cnu_nms`

## Requirements
- R1: After reset, `outValid` is 0 and both `record` and `msgs` are all zero.
- R2: `outValid` is 1 in exactly the cycles that follow a cycle with `inValid` at 1. The record and messages for that input appear in that same following cycle.
- R3: While `inValid` is 0, `record` and `msgs` keep their values, whatever `priors` and `laneEn` carry.
- R4: Among enabled lanes, the magnitude of each prior is taken as |x|, with -128 giving 128. The smallest magnitude selects the min1 lane; on a tie the lowest lane index wins, and the equal later value becomes the second minimum. With fewer than two enabled lanes, a missing minimum counts as magnitude 255. With no enabled lane, the index is 0.
- R5: Each stored minimum is (m>>1)+(m>>2) of the raw magnitude m, truncated, then saturated to 31.
- R6: The record layout is: min1 in bits [4:0], min2 in [9:5], min1 lane index in [13:10], lane sign bits in [28:14] (lane n at bit 14+n), and the sign product in bit 29.
- R7: A lane's stored sign bit is the prior's MSB if the lane is enabled and 0 otherwise. The sign product is the XOR of the signs of the enabled lanes.
- R8: The message for an enabled lane is 6-bit two's complement. Its magnitude is min2 on the min1 lane and min1 on every other lane. It is negative when the sign product XOR the lane's own sign is 1.
- R9: A lane that was disabled in the captured input has message 0, and it has no influence on the minima, the index or the sign product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Capture the lane inputs this cycle |
| laneEn | input | 15 | Per-lane enable mask, lane n at bit n |
| priors | input | 120 | Prior messages, lane n at bits [8n+7:8n], two's complement |
| outValid | output | 1 | Record and messages hold a fresh result |
| record | output | 30 | Compressed check-node record (layout in R6) |
| msgs | output | 90 | Expanded messages, lane n at bits [6n+5:6n], two's complement |

## Verification
All expanded messages are decoded from the registered record, so a wrong minimum, index or sign bit in state shows up both in the record field and in the messages of the affected lanes. It appears in the cycle right after the capturing `inValid`, and it persists through every hold cycle until the next capture. Ties, lone lanes, empty masks and the -128 extreme are driven on purpose, because a faulty comparison or a mask leak stays invisible on random data with distinct magnitudes. The bench compares every lane and every record field on every clock, so a state fault is reported within one cycle of becoming visible.

// File: rtl/cnu_pkg.sv
`timescale 1ns/1ps
package cnu_pkg;
  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic load;   // capture a new check-node result this cycle
  } cnu_strobe_t;
endpackage

// File: rtl/cnu_ctrl.sv
`timescale 1ns/1ps
module cnu_ctrl
  import cnu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output cnu_strobe_t strb,
  output logic        outValid
);
  // Capture is issued in the cycle the input is offered.
  always_comb begin
    strb.load = inValid;
  end

  // Flag a fresh result one cycle later.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/cnu_datapath.sv
`timescale 1ns/1ps
module cnu_datapath
  import cnu_pkg::*;
#(
  parameter  int DEG = 15,
  parameter  int PW  = 8,
  parameter  int MW  = 5,
  localparam int IW  = (DEG > 1) ? $clog2(DEG) : 1,
  localparam int OW  = MW + 1,
  localparam int RW  = 2*MW + IW + DEG + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  cnu_strobe_t       strb,
  input  logic [DEG-1:0]    laneEn,
  input  logic [DEG*PW-1:0] priors,
  output logic [RW-1:0]     record,
  output logic [DEG*OW-1:0] msgs
);
  localparam logic [PW-1:0] MAXM = PW'((1 << MW) - 1);

  function automatic logic [PW-1:0] absMag(input logic [PW-1:0] x);
    return x[PW-1] ? (~x + PW'(1)) : x;
  endfunction

  function automatic logic [MW-1:0] scaleSat(input logic [PW-1:0] m);
    logic [PW-1:0] s;
    s = (m >> 1) + (m >> 2);
    return (s > MAXM) ? MAXM[MW-1:0] : s[MW-1:0];
  endfunction

  // Search over the enabled lanes in index order.
  logic [PW-1:0]  curMin1, curMin2;
  logic [IW-1:0]  curIdx;
  logic [DEG-1:0] curSigns;
  logic           curProd;

  always_comb begin
    logic [PW-1:0] laneMag;
    curMin1  = '1;
    curMin2  = '1;
    curIdx   = '0;
    curSigns = '0;
    curProd  = 1'b0;
    for (int i = 0; i < DEG; i++) begin
      laneMag = absMag(priors[i*PW +: PW]);
      if (laneEn[i]) begin
        curSigns[i] = priors[i*PW + PW - 1];
        curProd     = curProd ^ priors[i*PW + PW - 1];
        if (laneMag < curMin1) begin
          curMin2 = curMin1;
          curMin1 = laneMag;
          curIdx  = IW'(i);
        end else if (laneMag < curMin2) begin
          curMin2 = laneMag;
        end
      end
    end
  end

  // Compressed record storage.
  logic [MW-1:0]  rMin1, rMin2;
  logic [IW-1:0]  rIdx;
  logic [DEG-1:0] rSigns, rMask;
  logic           rProd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rMin1  <= '0;
      rMin2  <= '0;
      rIdx   <= '0;
      rSigns <= '0;
      rMask  <= '0;
      rProd  <= 1'b0;
    end else if (strb.load) begin
      rMin1  <= scaleSat(curMin1);
      rMin2  <= scaleSat(curMin2);
      rIdx   <= curIdx;
      rSigns <= curSigns;
      rMask  <= laneEn;
      rProd  <= curProd;
    end
  end

  assign record = {rProd, rSigns, rIdx, rMin2, rMin1};

  // Per-lane decompression of the stored record.
  for (genvar g = 0; g < DEG; g++) begin : g_expand
    logic [MW-1:0] selMag;
    logic          neg;
    assign selMag = (rIdx == IW'(g)) ? rMin2 : rMin1;
    assign neg    = rProd ^ rSigns[g];
    assign msgs[g*OW +: OW] = rMask[g]
      ? (({1'b0, selMag} ^ {OW{neg}}) + OW'(neg))
      : '0;
  end
endmodule

// File: rtl/cnu_nms.sv
`timescale 1ns/1ps
module cnu_nms #(
  parameter  int DEG = 15,
  parameter  int PW  = 8,
  parameter  int MW  = 5,
  localparam int IW  = (DEG > 1) ? $clog2(DEG) : 1,
  localparam int OW  = MW + 1,
  localparam int RW  = 2*MW + IW + DEG + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DEG-1:0]    laneEn,
  input  logic [DEG*PW-1:0] priors,
  output logic              outValid,
  output logic [RW-1:0]     record,
  output logic [DEG*OW-1:0] msgs
);
  cnu_pkg::cnu_strobe_t strb;

  cnu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strb(strb), .outValid(outValid)
  );

  cnu_datapath #(.DEG(DEG), .PW(PW), .MW(MW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .laneEn(laneEn),
    .priors(priors), .record(record), .msgs(msgs)
  );
endmodule

// File: rtl/cnu_nms_checker.sv
`timescale 1ns/1ps
module cnu_nms_checker #(
  parameter  int DEG = 15,
  parameter  int PW  = 8,
  parameter  int MW  = 5,
  localparam int IW  = (DEG > 1) ? $clog2(DEG) : 1,
  localparam int OW  = MW + 1,
  localparam int RW  = 2*MW + IW + DEG + 1
)(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DEG-1:0]    laneEn,
  input logic              outValid,
  input logic [RW-1:0]     record,
  input logic [DEG*OW-1:0] msgs
);
  localparam int SB = 2*MW + IW;   // first lane sign bit
  localparam int PB = RW - 1;      // sign product bit

  a_r2_valid_after_capture: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r2_no_valid_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r3_record_held: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(record) && $stable(msgs));

  a_r4_min_order: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (record[MW-1:0] <= record[2*MW-1:MW]));

  for (genvar g = 0; g < DEG; g++) begin : g_lane
    a_r9_disabled_lane_zero: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && !laneEn[g]) |=> (msgs[g*OW +: OW] == '0) && !record[SB+g]);

    a_r8_lane_sign: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && laneEn[g]) |=> (msgs[g*OW +: OW] == '0) ||
        (msgs[g*OW + OW - 1] == (record[PB] ^ record[SB+g])));
  end
endmodule

bind cnu_nms cnu_nms_checker #(.DEG(DEG), .PW(PW), .MW(MW)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .laneEn(laneEn),
  .outValid(outValid), .record(record), .msgs(msgs)
);

// File: tb/cnu_nms_bench.sv
`timescale 1ns/1ps
module cnu_nms_bench;
  localparam int NL = 15;
  localparam int PW = 8;
  localparam int MW = 5;
  localparam int IW = 4;
  localparam int OW = MW + 1;
  localparam int RW = 2*MW + IW + NL + 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic [NL-1:0]     laneEn = '0;
  logic [NL*PW-1:0]  priors = '0;
  logic              outValid;
  logic [RW-1:0]     record;
  logic [NL*OW-1:0]  msgs;

  always #2.5 clk = ~clk;

  cnu_nms u_cnu_nms (
    .clk(clk), .rstN(rstN), .inValid(inValid), .laneEn(laneEn),
    .priors(priors), .outValid(outValid), .record(record), .msgs(msgs)
  );

  int checks = 0;
  int errors = 0;
  logic             expValid = 1'b0;
  logic [RW-1:0]    expRec = '0;
  logic [NL*OW-1:0] expMsg = '0;
  logic [NL-1:0]    expEn = '0;
  bit firstChk = 1'b1;
  bit lastIdle = 1'b0;

  task automatic cmp(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int sat(input int m);
    int s;
    s = (m / 2) + (m / 4);
    return (s > 31) ? 31 : s;
  endfunction

  // Behavioural model of one check node (R4..R9).
  task automatic model(input logic [NL-1:0] en, input logic [NL*PW-1:0] pv);
    int m1, m2, ix, s1, s2, v, mag, mm, val;
    bit pr;
    logic [NL-1:0] sg;
    logic signed [PW-1:0] raw;
    m1 = 255; m2 = 255; ix = 0; pr = 1'b0; sg = '0;
    for (int i = 0; i < NL; i++) begin
      if (en[i]) begin
        raw = pv[i*PW +: PW];
        v = raw;
        mag = (v < 0) ? -v : v;
        sg[i] = (v < 0);
        pr = pr ^ sg[i];
        if (mag < m1) begin m2 = m1; m1 = mag; ix = i; end
        else if (mag < m2) m2 = mag;
      end
    end
    s1 = sat(m1);
    s2 = sat(m2);
    // R6 layout: prod | signs | index | min2 | min1
    expRec = {pr, sg, IW'(ix), MW'(s2), MW'(s1)};
    for (int i = 0; i < NL; i++) begin
      if (!en[i]) expMsg[i*OW +: OW] = '0;
      else begin
        mm = (i == ix) ? s2 : s1;
        val = (pr ^ sg[i]) ? -mm : mm;
        expMsg[i*OW +: OW] = OW'(val);
      end
    end
    expEn = en;
  endtask

  task automatic checkNow();
    string tMin, tIdx, tSgn, tMsg;
    tMin = firstChk ? "R1" : (lastIdle ? "R3" : "R5");
    tIdx = firstChk ? "R1" : (lastIdle ? "R3" : "R4");
    tSgn = firstChk ? "R1" : (lastIdle ? "R3" : "R7");
    cmp(firstChk ? "R1" : "R2", "outValid", outValid, expValid);
    cmp(tMin, "min1", record[MW-1:0], expRec[MW-1:0]);
    cmp(tMin, "min2", record[2*MW-1:MW], expRec[2*MW-1:MW]);
    cmp(tIdx, "index", record[2*MW+IW-1:2*MW], expRec[2*MW+IW-1:2*MW]);
    cmp(tSgn, "signs", record[RW-1:2*MW+IW], expRec[RW-1:2*MW+IW]);
    for (int i = 0; i < NL; i++) begin
      tMsg = firstChk ? "R1" : (lastIdle ? "R3" : (expEn[i] ? "R8" : "R9"));
      cmp(tMsg, $sformatf("msg lane %0d", i), msgs[i*OW +: OW], expMsg[i*OW +: OW]);
    end
    firstChk = 1'b0;
  endtask

  task automatic step(input logic v, input logic [NL-1:0] en, input logic [NL*PW-1:0] pv);
    @(negedge clk);
    checkNow();
    inValid = v;
    laneEn = en;
    priors = pv;
    if (v) model(en, pv);
    expValid = v;
    lastIdle = !v;
  endtask

  function automatic logic [NL*PW-1:0] fill(input int val);
    logic [NL*PW-1:0] r;
    for (int i = 0; i < NL; i++) r[i*PW +: PW] = PW'(val);
    return r;
  endfunction

  function automatic logic [NL*PW-1:0] rnd(input int maxMag);
    logic [NL*PW-1:0] r;
    int v;
    for (int i = 0; i < NL; i++) begin
      v = $urandom_range(0, maxMag);
      if ($urandom_range(0, 1) == 1) v = -v;
      r[i*PW +: PW] = PW'(v);
    end
    return r;
  endfunction

  initial begin
    logic [NL*PW-1:0] pv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 checked on the first step, then general random patterns (R4, R5, R8)
    step(1'b1, '1, rnd(40));
    // R3: idle cycles with changing inputs
    step(1'b0, 15'h0F0F, rnd(60));
    step(1'b0, '0, rnd(127));
    // R4: all equal magnitudes, lowest index wins, second minimum equal
    pv = fill(-12);
    pv[3*PW +: PW] = 8'd12;
    step(1'b1, '1, pv);
    // R9: single enabled lane, missing second minimum saturates
    pv = fill(2);
    pv[6*PW +: PW] = PW'(-20);
    step(1'b1, 15'h0040, pv);
    // R9: no lane enabled
    step(1'b1, '0, rnd(50));
    // R5: extremes and saturation, -128 gives magnitude 128
    pv = fill(100);
    pv[0 +: PW] = 8'h80;
    pv[1*PW +: PW] = 8'd127;
    step(1'b1, '1, pv);
    // R5: small values, truncation of the scaling
    pv = fill(90);
    pv[7*PW +: PW] = 8'd3;
    pv[3*PW +: PW] = PW'(-1);
    pv[11*PW +: PW] = 8'd7;
    step(1'b1, 15'h7FF7, pv);
    // R8: minimum on the last lane, others negative
    pv = fill(-30);
    pv[14*PW +: PW] = PW'(-4);
    step(1'b1, '1, pv);
    // mixed random traffic and masks
    for (int k = 0; k < 300; k++) begin
      step(($urandom_range(0, 3) != 0), NL'($urandom), rnd((k % 3 == 0) ? 127 : 45));
    end
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule